// File: doc/BRIEF.md
# Oversampled Serial Receiver with Ready-to-Send Control

This block turns an asynchronous serial line into received characters. Software arms it with an enable input. The receiver first waits for the line to sit at its idle level. It then looks for a start bit, checks that start bit at mid-bit, and samples eight data bits. A ninth bit follows when it is configured, either as a plain data bit or as a parity bit. Last, the receiver checks one stop bit. Bit timing comes from an external pulse that arrives sixteen times per bit period, and every sample is taken by a majority of three tick samples.

The finished character is held in a data register, and a one-cycle completion pulse is raised. Sticky flags record completion, parity error and framing error; a read strobe clears all three. Overrun is also flagged and stays set until reset. The start level, which also sets the stop level, and the bit order are both configurable. With flow control on, a ready-to-send output (active low) invites the far end to transmit only while reception is enabled and the data register is empty.

Top module: `uart_rx_rts`

## Requirements
- R1: While `rx_en` is 0 the receiver stays idle: `rx_active` is 0 and no character is received, whatever happens on `rx_pin`. Once `rx_en` is 1, `rx_active` goes to 1.
- R2: When a frame completes, `rx_done_irq` is 1 for exactly one cycle, and in that cycle `rx_done` is 1 and `rx_active` is 0. While `rx_en` stays set, `rx_active` returns to 1 on the next cycle.
- R3: A one-cycle pulse on `rd_data` clears `rx_done`, `err_parity` and `err_frame` at the next edge, unless a frame completes at that same edge.
- R4: With `cfg_par_en`=1 the ninth bit slot carries parity. It is expected to equal the XOR of the eight data bits, inverted when `cfg_par_odd`=1. A mismatch sets `err_parity`. With `cfg_par_en`=0, `err_parity` is never set.
- R5: Only the first stop bit is checked. If its mid-bit majority equals `cfg_start_lvl` rather than the opposite level, `err_frame` is set. The character is still delivered.
- R6: With `cfg_flow_en`=1, `rts_n` is 0 exactly when `rx_en`=1 and `rx_done`=0 (registered, one cycle later). With `cfg_flow_en`=0, `rts_n` is 0.
- R7: A start bit is at level `cfg_start_lvl` and a stop bit is at the opposite level. Data bits are never inverted. With `cfg_msb_first`=0 the first data bit lands in `rx_data[0]`; with `cfg_msb_first`=1 it lands in `rx_data[7]`. The ninth bit always follows the eight data bits.
- R8: A start level seen on a tick is accepted as a start bit only if the majority of the three tick samples ending 8 ticks later is still the start level. Otherwise hunting resumes, and no character or flag results.
- R9: A frame that completes while `rx_done` is 1 and no read occurs at the same edge overwrites the data register and sets `err_overrun`. `err_overrun` is cleared only by reset.
- R10: With `cfg_nine`=1 and `cfg_par_en`=0, the ninth received bit appears on `rx_bit9`. In 8-bit frames without parity, `rx_bit9` is 0.
- R11: After enabling and after each frame, hunting starts only once the line has been seen at the idle level (not `cfg_start_lvl`). A stop bit at the wrong level therefore cannot start a false frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, OVS per bit period |
| rx_en | input | 1 | Receive enable |
| cfg_nine | input | 1 | Ninth data bit present |
| cfg_par_en | input | 1 | Ninth slot is parity and is checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_start_lvl | input | 1 | Line level of the start bit |
| cfg_msb_first | input | 1 | 1 receives the most significant bit first |
| cfg_flow_en | input | 1 | Enables ready-to-send control |
| rx_pin | input | 1 | Serial input line |
| rd_data | input | 1 | Data register read strobe |
| rx_data | output | DATA_W | Received character |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_done_irq | output | 1 | Completion pulse |
| rx_done | output | 1 | Sticky completion flag |
| rx_active | output | 1 | Receiver armed or receiving |
| err_parity | output | 1 | Parity error flag |
| err_frame | output | 1 | Framing error flag |
| err_overrun | output | 1 | Sticky overrun flag |
| rts_n | output | 1 | Ready to send, active low |

## Verification
The assertions assume that `rd_data` is a single-cycle strobe and that no frame completes in the cycle right after a read. They also assume that the configuration inputs change only while no frame is in flight, since the parity and flow checks relate a configuration value to the flag one cycle later. The stimulus changes configuration only between frames, after the expected character has been consumed. It drives bit periods that are exact multiples of the tick period, and it issues every read as a one-cycle pulse well clear of the next stop bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_rx_sync_vote.sv
module uart_rx_sync_vote import uart_rx_pkg::*; #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx_pin,
  output logic line,
  output logic vote
);
  logic [SYNC-1:0] sync_q;
  logic [1:0]      win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      win_q  <= 2'b11;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], rx_pin};
      if (tick) win_q <= {win_q[0], sync_q[SYNC-1]};
    end
  end

  assign line = sync_q[SYNC-1];
  assign vote = maj3(win_q[1], win_q[0], line);
endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  output logic mid
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (tick) begin
      if (restart) cnt_q <= '0;
      else if (cnt_q == CW'(OVS - 1)) cnt_q <= '0;
      else cnt_q <= cnt_q + CW'(1);
    end
  end

  assign mid = tick && !restart && (cnt_q == CW'(MID - 1));
endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter #(
  parameter int DATA_W = 8,
  localparam int IW = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift,
  input  logic              bit_in,
  input  logic [IW-1:0]     idx,
  input  logic              msb_first,
  output logic [DATA_W-1:0] data,
  output logic              extra
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic hit;
    assign hit = msb_first ? (idx == IW'(DATA_W - 1 - g)) : (idx == IW'(g));
    always_ff @(posedge clk) begin
      if (rst || clear) data[g] <= 1'b0;
      else if (shift && hit) data[g] <= bit_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) extra <= 1'b0;
    else if (shift && idx == IW'(DATA_W)) extra <= bit_in;
  end
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts import uart_rx_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_en,
  input  logic              cfg_nine,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_start_lvl,
  input  logic              cfg_msb_first,
  input  logic              cfg_flow_en,
  input  logic              rx_pin,
  input  logic              rd_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_done_irq,
  output logic              rx_done,
  output logic              rx_active,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              rts_n
);
  localparam int IW = $clog2(DATA_W + 1);

  logic            line, vote, mid, restart;
  logic            sh_clear, sh_shift, sh_extra, complete;
  logic [DATA_W-1:0] sh_data;
  rx_state_t       state_q, state_n;
  logic [IW-1:0]   idx_q, idx_n, last_idx;
  logic            par_bad, stop_bad, done_n;

  uart_rx_sync_vote #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst(rst), .tick(tick), .rx_pin(rx_pin),
    .line(line), .vote(vote)
  );

  uart_rx_timer #(.OVS(OVS)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart), .mid(mid)
  );

  uart_rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .clear(sh_clear), .shift(sh_shift), .bit_in(vote),
    .idx(idx_q), .msb_first(cfg_msb_first), .data(sh_data), .extra(sh_extra)
  );

  assign last_idx = (cfg_nine || cfg_par_en) ? IW'(DATA_W) : IW'(DATA_W - 1);

  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    restart  = 1'b0;
    sh_clear = 1'b0;
    sh_shift = 1'b0;
    complete = 1'b0;
    if (!rx_en) state_n = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:  state_n = ST_ARM;
        ST_ARM:   if (tick && line != cfg_start_lvl) state_n = ST_HUNT;
        ST_HUNT:  if (tick && line == cfg_start_lvl) begin
                    state_n = ST_START;
                    restart = 1'b1;
                  end
        ST_START: if (mid) begin
                    if (vote == cfg_start_lvl) begin
                      state_n  = ST_DATA;
                      idx_n    = '0;
                      sh_clear = 1'b1;
                    end else state_n = ST_HUNT;
                  end
        ST_DATA:  if (mid) begin
                    sh_shift = 1'b1;
                    if (idx_q == last_idx) state_n = ST_STOP;
                    else idx_n = idx_q + IW'(1);
                  end
        ST_STOP:  if (mid) begin
                    complete = 1'b1;
                    state_n  = ST_IDLE;
                  end
        default:  state_n = ST_IDLE;
      endcase
    end
  end

  assign par_bad  = cfg_par_en && ((^sh_data ^ cfg_par_odd) != sh_extra);
  assign stop_bad = (vote == cfg_start_lvl);
  assign done_n   = complete ? 1'b1 : (rd_data ? 1'b0 : rx_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      rx_data     <= '0;
      rx_bit9     <= 1'b0;
      rx_done_irq <= 1'b0;
      rx_done     <= 1'b0;
      rx_active   <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      rts_n       <= 1'b0;
    end else begin
      state_q     <= state_n;
      idx_q       <= idx_n;
      rx_active   <= (state_n != ST_IDLE);
      rx_done_irq <= complete;
      rx_done     <= done_n;
      rts_n       <= cfg_flow_en && !(rx_en && !done_n);
      if (complete) begin
        rx_data    <= sh_data;
        rx_bit9    <= (cfg_nine || cfg_par_en) ? sh_extra : 1'b0;
        err_parity <= par_bad;
        err_frame  <= stop_bad;
        if (rx_done && !rd_data) err_overrun <= 1'b1;
      end else if (rd_data) begin
        err_parity <= 1'b0;
        err_frame  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx_rts_chk.sv
module uart_rx_rts_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic rd_data,
  input logic cfg_flow_en,
  input logic cfg_par_en,
  input logic rx_done_irq,
  input logic rx_done,
  input logic rx_active,
  input logic err_parity,
  input logic err_overrun,
  input logic rts_n
);
  // R1
  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_active);
  // R2
  p_done_drops_active_r2: assert property (@(posedge clk) disable iff (rst)
    rx_done_irq |-> (rx_done && !rx_active));
  p_irq_single_r2: assert property (@(posedge clk) disable iff (rst)
    rx_done_irq |=> !rx_done_irq);
  // R3
  p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
    rd_data |=> (!rx_done || rx_done_irq));
  // R4
  p_no_parity_err_r4: assert property (@(posedge clk) disable iff (rst)
    !cfg_par_en |=> (!rx_done_irq || !err_parity));
  // R6
  p_rts_off_r6: assert property (@(posedge clk) disable iff (rst)
    !cfg_flow_en |=> !rts_n);
  p_rts_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_flow_en && !rx_en) |=> rts_n);
  // R9
  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_overrun |=> err_overrun);
endmodule

bind uart_rx_rts uart_rx_rts_chk u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .rd_data(rd_data),
  .cfg_flow_en(cfg_flow_en), .cfg_par_en(cfg_par_en),
  .rx_done_irq(rx_done_irq), .rx_done(rx_done), .rx_active(rx_active),
  .err_parity(err_parity), .err_overrun(err_overrun), .rts_n(rts_n)
);

// File: tb/tb_uart_rx_rts.sv
module tb_uart_rx_rts;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int OVS = 16;
  localparam int TDIV = 4;
  localparam int BITCLK = OVS * TDIV;

  logic clk = 0, rst = 1, tick = 0;
  logic rx_en = 0, cfg_nine = 0, cfg_par_en = 0, cfg_par_odd = 0;
  logic cfg_start_lvl = 0, cfg_msb_first = 0, cfg_flow_en = 0;
  logic rx_pin = 1, rd_data = 0;
  logic [DATA_W-1:0] rx_data;
  logic rx_bit9, rx_done_irq, rx_done, rx_active, err_parity, err_frame, err_overrun, rts_n;

  int total = 0, bad = 0;
  int tcnt = 0;
  bit auto_read = 1;
  logic [10:0] expq[$];

  uart_rx_rts #(.DATA_W(DATA_W), .OVS(OVS)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == TDIV - 1);
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd_data = 1;
    @(negedge clk); rd_data = 0;
  endtask

  // drive one frame; push the expected {perr, ferr, bit9, data} when push=1
  task automatic send(input logic [8:0] val, input bit bad_par, input bit bad_stop, input bit push);
    logic par, ninth;
    par = ^val[7:0] ^ cfg_par_odd ^ bad_par;
    ninth = cfg_par_en ? par : val[8];
    if (push)
      expq.push_back({cfg_par_en & bad_par, bad_stop,
                      (cfg_par_en | cfg_nine) ? ninth : 1'b0, val[7:0]});
    @(negedge clk); rx_pin = cfg_start_lvl; hold(BITCLK);
    for (int i = 0; i < 8; i++) begin
      rx_pin = cfg_msb_first ? val[7-i] : val[i];
      hold(BITCLK);
    end
    if (cfg_par_en || cfg_nine) begin rx_pin = ninth; hold(BITCLK); end
    rx_pin = bad_stop ? cfg_start_lvl : ~cfg_start_lvl; hold(BITCLK);
    rx_pin = ~cfg_start_lvl; hold(2 * BITCLK);
    wait (expq.size() == 0);
    hold(8);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rx_done_irq) begin
        logic [10:0] e;
        if (expq.size() == 0) begin
          chk("R2 unexpected frame", 16'(rx_data), 16'hFFFF);
        end else begin
          e = expq.pop_front();
          chk("R7 data", 16'(rx_data), 16'(e[7:0]));
          chk("R10 ninth bit", 16'(rx_bit9), 16'(e[8]));
          chk("R5 framing flag", 16'(err_frame), 16'(e[9]));
          chk("R4 parity flag", 16'(err_parity), 16'(e[10]));
          chk("R2 done set, active low", {14'd0, rx_done, rx_active}, 16'b10);
          @(negedge clk);
          chk("R2 irq single / active back", {14'd0, rx_done_irq, rx_active}, 16'b01);
          if (auto_read) begin
            rd_data = 1; @(negedge clk); rd_data = 0; @(negedge clk);
            chk("R3 read clears flags", {13'd0, rx_done, err_parity, err_frame}, 16'd0);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    hold(5); rst = 0; hold(2);
    chk("R1 reset outputs",
        {9'd0, rx_active, rx_done, rx_done_irq, err_parity, err_frame, err_overrun, rts_n}, 16'd0);

    // R1: disabled receiver ignores the line
    send(9'h0A5, 0, 0, 0);
    chk("R1 ignored when off", {14'd0, rx_done, rx_active}, 16'd0);

    cfg_flow_en = 1; hold(3);
    chk("R6 rts high while disabled", 16'(rts_n), 16'd1);
    rx_en = 1; hold(3);
    chk("R1 active after enable", 16'(rx_active), 16'd1);
    chk("R6 rts low when empty", 16'(rts_n), 16'd0);

    // basic 8-bit LSB first
    send(9'h0C3, 0, 0, 1);
    send(9'h05A, 0, 0, 1);

    // R8: short glitch is rejected
    @(negedge clk); rx_pin = 0; hold(2 * TDIV); rx_pin = 1; hold(3 * BITCLK);
    chk("R8 glitch no frame", {14'd0, rx_done, rx_active}, 16'b01);
    send(9'h081, 0, 0, 1);

    // R7: MSB first, inverted start level
    cfg_msb_first = 1; cfg_start_lvl = 1; rx_pin = 0; hold(3 * BITCLK);
    send(9'h0B4, 0, 0, 1);
    cfg_msb_first = 0; cfg_start_lvl = 0; rx_pin = 1; hold(3 * BITCLK);

    // R10: nine data bits
    cfg_nine = 1;
    send(9'h1E7, 0, 0, 1);
    send(9'h012, 0, 0, 1);
    cfg_nine = 0;

    // R4: even and odd parity, good and bad
    cfg_par_en = 1;
    send(9'h037, 0, 0, 1);
    send(9'h037, 1, 0, 1);
    cfg_par_odd = 1;
    send(9'h0F0, 0, 0, 1);
    send(9'h0F1, 1, 0, 1);
    cfg_par_en = 0; cfg_par_odd = 0;

    // R5 / R11: bad stop bit, no false frame after it
    send(9'h066, 0, 1, 1);
    hold(4 * BITCLK);
    chk("R11 no false frame", 16'(rx_done), 16'd0);

    // R9 overrun and R6 rts with unread byte
    auto_read = 0;
    send(9'h011, 0, 0, 1);
    chk("R6 rts high when full", 16'(rts_n), 16'd1);
    chk("R9 no overrun yet", 16'(err_overrun), 16'd0);
    send(9'h022, 0, 0, 1);
    chk("R9 overrun set", 16'(err_overrun), 16'd1);
    chk("R9 data overwritten", 16'(rx_data), 16'h0022);
    do_read(); hold(2);
    chk("R3 done cleared by read", 16'(rx_done), 16'd0);
    chk("R9 overrun sticky", 16'(err_overrun), 16'd1);
    chk("R6 rts low after read", 16'(rts_n), 16'd0);
    auto_read = 1;

    cfg_flow_en = 0; hold(3);
    chk("R6 rts low without flow", 16'(rts_n), 16'd0);
    rx_en = 0; hold(3);
    chk("R1 inactive after disable", 16'(rx_active), 16'd0);
    chk("R2 queue drained", 16'(expq.size()), 16'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule